// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block is the storage side of a physical memory protection unit. It holds one 8-bit configuration byte and one address register for each of `N` protection entries. It also holds a three-bit machine security configuration register. Software reaches all of it through a simple CSR port made of a register kind select, an index, a write enable, write data and combinational read data. Configuration bytes are packed several to a CSR word. Address registers and the security register are one word each.

The block does not pass every write through. A write can be blocked by the lock bit of the entry itself. An address write can also be blocked by the lock of the next entry when that entry uses the preceding address as its lower bound. When the enhanced security mode is built in, the security register adds three controls: a bypass bit that lifts the locks, a lockdown bit that replaces the plain lock rule with a rule based on the new value, and a whitelist bit. The lockdown and whitelist bits cannot be cleared once set.

The raw configuration and address arrays, together with the security bits, go to the region decoder. A one-cycle update pulse tells the decoder to refresh whenever a configuration or address value has actually changed. The default build has the enhanced mode enabled.

Top module: `pmp_csr_file`

## Requirements
- R1: After reset every configuration byte, address register and security bit reads as zero, and `upd_o` is low.
- R2: A configuration CSR write with index k puts data byte i (bits [8i+7:8i]) into entry k*4+i, and a read returns those entry bytes in the same positions. Within a byte, R is bit 0, W bit 1, X bit 2, the match mode is bits [4:3] (01 means the entry is bounded below by the previous address) and L is bit 7.
- R3: While the bypass bit and the lockdown bit are both clear, a configuration write to an entry whose L bit is set leaves that byte unchanged.
- R4: While the bypass bit is set, a configuration write is accepted whatever the current L bit is.
- R5: While the lockdown bit is set and the bypass bit is clear, a configuration byte is accepted only if the new value has L=1 and X=0, or has L=0 and an RWX field other than exactly W|X (3'b110). Otherwise the byte is unchanged. This rule applies even if the entry is currently locked.
- R6: An address write to an entry whose own L bit is set is ignored.
- R7: An address write to entry e is ignored when entry e+1 has L=1 and match mode 01. If entry e+1 is locked with any other mode, the write is accepted.
- R8: Writing a 1 to the bypass bit has no effect while that bit is 0 and any entry has L set.
- R9: The security register has lockdown at bit 0, whitelist at bit 1 and bypass at bit 2, and its other read bits are zero. Once the lockdown or whitelist bit is set, a later write cannot clear it.
- R10: Writes to an entry index at or above N are ignored, and reads of such an entry return zero in its byte or word.
- R11: `upd_o` is high for exactly the one cycle after a clock edge on which a configuration or address value changed. A write that changes nothing does not raise it.

Select encoding: `csr_kind` 00 = configuration, 01 = address, 10 = security, 11 = none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_kind | input | 2 | Register kind: 00 cfg, 01 addr, 10 security, 11 none |
| csr_idx | input | IDX_W | CSR index within the kind |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected register (combinational) |
| cfg_o | output | N*8 | All configuration bytes, entry e at [8e+7:8e] |
| addr_o | output | N*XLEN | All address registers, entry e at word e |
| sec_o | output | 3 | Security bits {bypass, whitelist, lockdown} |
| upd_o | output | 1 | One-cycle pulse after a cfg or addr value changed |

## Verification
The write-acceptance logic is driven with one sequence that moves from open entries to locked ones and then into lockdown. Each step is checked by reading back the register and the update pulse, so a rejected write can be told apart from an accepted write that happens to store the same value. The address tests separate a lock on the entry itself from a lock on the next entry, and a next entry locked in bounded-below mode from one locked in another mode. The lockdown tests feed a locked executable value, a locked non-executable value and a shared write-execute value, so each arm of the acceptance rule is exercised on its own. Directed runs after a fresh reset cover the bypass bit: it can be set and lifts the locks while no entry is locked, and it is refused once one is.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;
  typedef enum logic [1:0] {
    KIND_CFG  = 2'b00,
    KIND_ADDR = 2'b01,
    KIND_SEC  = 2'b10,
    KIND_NONE = 2'b11
  } csr_kind_e;

  localparam int CFG_R   = 0;
  localparam int CFG_W   = 1;
  localparam int CFG_X   = 2;
  localparam int CFG_L   = 7;
  localparam logic [1:0] MODE_TOR = 2'b01;

  localparam int SEC_LOCKDOWN = 0;
  localparam int SEC_WLIST    = 1;
  localparam int SEC_BYPASS   = 2;

  localparam int ENTRY_STRIDE = 4;
endpackage

// File: rtl/pmp_cfg_gate.sv
module pmp_cfg_gate
  import pmp_csr_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic [7:0] cur_cfg,
  input  logic [7:0] new_cfg,
  input  logic       lockdown,
  input  logic       bypass,
  output logic       accept
);
  logic plain_ok;
  logic ld_ok;

  always_comb begin
    plain_ok = !cur_cfg[CFG_L];
    ld_ok = (new_cfg[CFG_L] && !new_cfg[CFG_X]) ||
            (!new_cfg[CFG_L] && (new_cfg[2:0] != 3'b110));
  end

  generate
    if (ENHANCED) begin : g_enh
      assign accept = bypass || (!lockdown && plain_ok) || (lockdown && ld_ok);
    end else begin : g_plain
      logic unused_sig;
      assign unused_sig = lockdown ^ bypass;
      assign accept = plain_ok;
    end
  endgenerate
endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
  import pmp_csr_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_bits,
  input  logic       any_locked,
  output logic [2:0] sec_q
);
  logic [2:0] sec_d;
  logic       new_bypass;

  always_comb begin
    new_bypass = wr_bits[SEC_BYPASS] && (sec_q[SEC_BYPASS] || !any_locked);
    sec_d = {new_bypass,
             wr_bits[SEC_WLIST] | sec_q[SEC_WLIST],
             wr_bits[SEC_LOCKDOWN] | sec_q[SEC_LOCKDOWN]};
    if (!ENHANCED) sec_d = 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 3'b000;
    end else if (wr_en) begin
      sec_q <= sec_d;
    end
  end
endmodule

// File: rtl/pmp_csr_file.sv
module pmp_csr_file
  import pmp_csr_pkg::*;
#(
  parameter int N        = 8,
  parameter int XLEN     = 32,
  parameter int IDX_W    = 8,
  parameter bit ENHANCED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_kind,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic [N*8-1:0]    cfg_o,
  output logic [N*XLEN-1:0] addr_o,
  output logic [2:0]        sec_o,
  output logic              upd_o
);
  localparam int BPC = XLEN / 8;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [N-1:0][7:0]      cfg_q, cfg_d;
  logic [N-1:0][XLEN-1:0] addr_q, addr_d;
  logic [N-1:0][7:0]      cfg_new;
  logic [N-1:0]           cfg_hit, cfg_ok, addr_blk;
  logic [2:0]             sec_q;
  logic                   any_locked;
  logic                   upd_q;
  logic                   wr_cfg, wr_addr, wr_sec, reg_en;

  assign wr_cfg  = csr_we && (csr_kind == KIND_CFG);
  assign wr_addr = csr_we && (csr_kind == KIND_ADDR);
  assign wr_sec  = csr_we && (csr_kind == KIND_SEC);
  assign reg_en  = wr_cfg || wr_addr;

  always_comb begin
    cfg_hit = '0;
    cfg_new = '0;
    for (int e = 0; e < N; e++) begin
      for (int i = 0; i < BPC; i++) begin
        if (int'(csr_idx) * ENTRY_STRIDE + i == e) begin
          cfg_hit[e] = 1'b1;
          cfg_new[e] = csr_wdata[8*i +: 8];
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      pmp_cfg_gate #(.ENHANCED(ENHANCED)) u_gate (
        .cur_cfg  (cfg_q[g]),
        .new_cfg  (cfg_new[g]),
        .lockdown (sec_q[SEC_LOCKDOWN]),
        .bypass   (sec_q[SEC_BYPASS]),
        .accept   (cfg_ok[g])
      );
      if (g + 1 < N) begin : g_nxt
        assign addr_blk[g] = cfg_q[g][CFG_L] ||
                             (cfg_q[g+1][CFG_L] && (cfg_q[g+1][4:3] == MODE_TOR));
      end else begin : g_top
        assign addr_blk[g] = cfg_q[g][CFG_L];
      end
    end
  endgenerate

  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    for (int e = 0; e < N; e++) begin
      if (wr_cfg && cfg_hit[e] && cfg_ok[e]) cfg_d[e] = cfg_new[e];
      if (wr_addr && (int'(csr_idx) == e) && !addr_blk[e]) addr_d[e] = csr_wdata;
    end
  end

  always_comb begin
    any_locked = 1'b0;
    for (int e = 0; e < N; e++) any_locked = any_locked | cfg_q[e][CFG_L];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (reg_en) begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) upd_q <= 1'b0;
    else            upd_q <= (cfg_d != cfg_q) || (addr_d != addr_q);
  end

  pmp_sec_reg #(.ENHANCED(ENHANCED)) u_sec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_sec),
    .wr_bits    (csr_wdata[2:0]),
    .any_locked (any_locked),
    .sec_q      (sec_q)
  );

  always_comb begin
    csr_rdata = '0;
    case (csr_kind)
      KIND_CFG: begin
        for (int e = 0; e < N; e++) begin
          for (int i = 0; i < BPC; i++) begin
            if (int'(csr_idx) * ENTRY_STRIDE + i == e) csr_rdata[8*i +: 8] = cfg_q[e];
          end
        end
      end
      KIND_ADDR: begin
        for (int e = 0; e < N; e++) begin
          if (int'(csr_idx) == e) csr_rdata = addr_q[e];
        end
      end
      KIND_SEC: csr_rdata[2:0] = sec_q;
      default:  csr_rdata = '0;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;
  assign sec_o  = sec_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/pmp_csr_file_chk.sv
module pmp_csr_file_chk #(
  parameter int N  = 8,
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N*8-1:0]  cfg_i,
  input logic [N*AW-1:0] addr_i,
  input logic [2:0]      sec_i,
  input logic            upd_i
);
  logic any_l;
  always_comb begin
    any_l = 1'b0;
    for (int e = 0; e < N; e++) any_l = any_l | cfg_i[8*e+7];
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_e
      // R3: locked byte holds while neither bypass nor lockdown is set
      assert_locked_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[8*g+7] && !sec_i[0] && !sec_i[2]) |=> (cfg_i[8*g +: 8] == $past(cfg_i[8*g +: 8])));
      // R6: locked entry keeps its address
      assert_locked_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[8*g+7] |=> $stable(addr_i[AW*g +: AW]));
    end
  endgenerate

  assert_lockdown_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_i[0] |=> sec_i[0]);
  assert_wlist_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_i[1] |=> sec_i[1]);
  assert_bypass_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_i[2] && any_l) |=> !sec_i[2]);
  assert_pulse_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_i != $past(cfg_i)) || (addr_i != $past(addr_i))) |-> upd_i);
  assert_pulse_only_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |-> ((cfg_i != $past(cfg_i)) || (addr_i != $past(addr_i))));
endmodule

bind pmp_csr_file pmp_csr_file_chk #(.N(N), .AW(XLEN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .cfg_i  (cfg_o),
  .addr_i (addr_o),
  .sec_i  (sec_o),
  .upd_i  (upd_o)
);

// File: tb/sim_pmp_csr_file.sv
module sim_pmp_csr_file;
  localparam int N = 8;
  localparam int XLEN = 32;
  localparam int IDX_W = 8;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_kind = 2'b11;
  logic [IDX_W-1:0] csr_idx = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic [N*8-1:0] cfg_o;
  logic [N*XLEN-1:0] addr_o;
  logic [2:0] sec_o;
  logic upd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmp_csr_file #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W), .ENHANCED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_kind(csr_kind),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cfg_o(cfg_o), .addr_o(addr_o), .sec_o(sec_o), .upd_o(upd_o)
  );

  // {kind[1:0], idx[7:0], wdata[31:0], expected read[31:0], expected pulse}
  localparam logic [74:0] VEC [NV] = '{
    {2'b00, 8'd0, 32'h0B0A0908, 32'h0B0A0908, 1'b1}, // R2 packing
    {2'b00, 8'd1, 32'h00000018, 32'h00000018, 1'b1}, // R2 second word
    {2'b01, 8'd0, 32'h12345678, 32'h12345678, 1'b1}, // R11 addr change
    {2'b01, 8'd0, 32'h12345678, 32'h12345678, 1'b0}, // R11 same value
    {2'b00, 8'd2, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R10 cfg out of range
    {2'b01, 8'd9, 32'h0000AAAA, 32'h00000000, 1'b0}, // R10 addr out of range
    {2'b00, 8'd0, 32'h00000088, 32'h00000088, 1'b1}, // lock entry0
    {2'b00, 8'd0, 32'h00000000, 32'h00000088, 1'b0}, // R3 locked cfg
    {2'b01, 8'd0, 32'h00000001, 32'h12345678, 1'b0}, // R6 locked addr
    {2'b00, 8'd0, 32'h00008800, 32'h00008888, 1'b1}, // R3 partial
    {2'b00, 8'd0, 32'h88000000, 32'h88008888, 1'b1}, // lock entry3 TOR
    {2'b01, 8'd2, 32'h00000055, 32'h00000000, 1'b0}, // R7 next locked TOR
    {2'b00, 8'd1, 32'h00008000, 32'h00008000, 1'b1}, // entry5 locked off
    {2'b01, 8'd4, 32'h00000077, 32'h00000077, 1'b1}, // R7 next locked not TOR
    {2'b10, 8'd0, 32'h00000004, 32'h00000000, 1'b0}, // R8 bypass refused
    {2'b10, 8'd0, 32'h00000003, 32'h00000003, 1'b0}, // R9 set lockdown/wlist
    {2'b10, 8'd0, 32'h00000000, 32'h00000003, 1'b0}, // R9 sticky
    {2'b00, 8'd1, 32'h00060000, 32'h00000000, 1'b1}, // R5 WX refused, L=0 taken
    {2'b00, 8'd1, 32'h8C000000, 32'h00000000, 1'b0}, // R5 locked exec refused
    {2'b00, 8'd1, 32'h8B000000, 32'h8B000000, 1'b1}  // R5 locked non-exec taken
  };

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write at a falling edge, commit at the rising edge, sample at the next falling edge
  task automatic wr_rd(input logic [1:0] k, input logic [7:0] ix, input logic [31:0] wd,
                       input logic [31:0] exp_rd, input logic exp_up, input string req);
    @(negedge clk);
    csr_kind = k; csr_idx = ix; csr_wdata = wd; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    #1;
    check(req, csr_rdata, exp_rd);
    check({req, " pulse R11"}, {31'd0, upd_o}, {31'd0, exp_up});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    csr_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] k, input logic [7:0] ix, input logic [31:0] exp, input string req);
    @(negedge clk);
    csr_kind = k; csr_idx = ix;
    #1;
    check(req, csr_rdata, exp);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    rd(2'b00, 8'd0, 32'h0, "R1 cfg0");
    rd(2'b00, 8'd1, 32'h0, "R1 cfg1");
    rd(2'b01, 8'd0, 32'h0, "R1 addr0");
    rd(2'b10, 8'd0, 32'h0, "R1 sec");
    check("R1 pulse", {31'd0, upd_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      wr_rd(VEC[v][74:73], VEC[v][72:65], VEC[v][64:33], VEC[v][32:1], VEC[v][0],
            $sformatf("vec%0d", v));
    end
    check("R2 cfg_o entry7", {24'd0, cfg_o[63:56]}, 32'h8B);

    // bypass path after a fresh reset
    do_reset();
    rd(2'b00, 8'd0, 32'h0, "R1 after reset");
    wr_rd(2'b10, 8'd0, 32'h4, 32'h4, 1'b0, "R8 bypass set when unlocked");
    wr_rd(2'b00, 8'd0, 32'h80, 32'h80, 1'b1, "R4 lock entry0");
    wr_rd(2'b00, 8'd0, 32'h00, 32'h00, 1'b1, "R4 bypass overrides lock");
    wr_rd(2'b00, 8'd0, 32'h80, 32'h80, 1'b1, "R4 relock");
    wr_rd(2'b10, 8'd0, 32'h4, 32'h4, 1'b0, "R8 bypass kept while set");
    wr_rd(2'b10, 8'd0, 32'h0, 32'h0, 1'b0, "R9 bypass clearable");
    wr_rd(2'b00, 8'd0, 32'h00, 32'h80, 1'b0, "R3 lock holds");
    wr_rd(2'b10, 8'd0, 32'hFFFFFFFC, 32'h0, 1'b0, "R8 bypass refused, R9 upper bits zero");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule